// File: doc/BRIEF.md
# Pairwise Address Swap Remapper

This block sits on the address path between a processor and a banked memory. It moves a few heavily used addresses into a dense low region, so that a small bank placed there receives most of the traffic. It holds a table of PAIRS entries. Each entry ties one "hot" address to one low slot, a number from 0 to PAIRS-1. The address of a slot is that number, zero-extended to the full address width. Every entry defines a swap. An incoming address equal to the hot address leaves as the slot address, and an incoming address equal to the slot address leaves as the hot address. Any address that no valid entry names leaves unchanged.

The translation is purely combinational: the output follows the input in the same cycle. The only state is the pair table, which a one-entry-per-cycle write port loads. Each entry carries a valid flag. Choosing which addresses are hot, and decoding the remapped address into banks, belong to other blocks.

Top module: `addr_swap_remap`

## Requirements
- R1: When no valid entry names the input address as its hot address or as its slot address, out_addr equals in_addr.
- R2: When the selected entry's hot address equals in_addr, out_addr is that entry's slot number, zero-extended to ADDR_W bits.
- R3: When the selected entry's slot address (the slot number, zero-extended) equals in_addr, out_addr is that entry's hot address.
- R4: With valid entries whose hot addresses are distinct, whose slots are distinct and whose hot addresses all lie at or above PAIRS, remapping an address and then remapping the result gives back the original address.
- R5: A write with cfg_we high stores cfg_hot, cfg_slot and cfg_valid into entry cfg_idx at the rising clock edge, and it changes no other entry. The new mapping is visible from that edge on. With cfg_we low, the table holds its contents.
- R6: An entry whose valid flag is 0 takes no part in remapping, whatever its hot address and slot hold.
- R7: An active-low reset clears every valid flag, so that after reset every address passes through unchanged.
- R8: When several valid entries name the input address, the entry with the lowest index decides the output.
- R9: out_addr responds to a change of in_addr within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pair table |
| rst_n | input | 1 | Active-low reset; clears all valid flags |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | IDX_W | Entry to write |
| cfg_hot | input | ADDR_W | Hot address for the entry |
| cfg_slot | input | IDX_W | Low slot number for the entry |
| cfg_valid | input | 1 | Valid flag for the entry |
| in_addr | input | ADDR_W | Address from the processor |
| out_addr | output | ADDR_W | Remapped address toward the memory banks |

## Verification
Every cycle, the assertions check the structural rules of the lookup. With no winner, the address passes through. At most one entry wins, and it is the lowest matching index. An invalid entry never raises a match. A hot-side win always produces an address inside the low region. A slot-side win occurs only for an input inside that region. The table also holds still when no write occurs. The bench scenarios show what needs concrete values: the actual swapped addresses, the round trip that returns the original address, priority between duplicate entries, a reset in mid-run that erases a loaded table, and the output settling between clock edges.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_PAIRS  = 8;

  // Which member of a pair the input address matched.
  typedef enum logic {
    SIDE_SLOT = 1'b0,
    SIDE_HOT  = 1'b1
  } side_e;
endpackage

// File: rtl/remap_table.sv
module remap_table #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAIRS  = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [ADDR_W-1:0]       hot,
  input  logic [IDX_W-1:0]        slot,
  input  logic                    valid,
  output logic [PAIRS*ADDR_W-1:0] hot_flat,
  output logic [PAIRS*IDX_W-1:0]  slot_flat,
  output logic [PAIRS-1:0]        valid_vec
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_entry
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic sel;
    assign sel = we && (idx == MY_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_vec[i] <= 1'b0;
      end else if (sel) begin
        valid_vec[i] <= valid;
      end
    end

    // Hot address and slot need no reset: an invalid entry never matches.
    always_ff @(posedge clk) begin
      if (sel) begin
        hot_flat[i*ADDR_W +: ADDR_W] <= hot;
        slot_flat[i*IDX_W +: IDX_W]  <= slot;
      end
    end
  end
endmodule

// File: rtl/remap_match.sv
module remap_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAIRS  = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [PAIRS*ADDR_W-1:0] hot_flat,
  input  logic [PAIRS*IDX_W-1:0]  slot_flat,
  input  logic [PAIRS-1:0]        valid_vec,
  output logic [PAIRS-1:0]        hit_hot,
  output logic [PAIRS-1:0]        hit_slot
);
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] s);
    return {{(ADDR_W-IDX_W){1'b0}}, s};
  endfunction

  for (genvar i = 0; i < PAIRS; i++) begin : g_cmp
    assign hit_hot[i]  = valid_vec[i] && (in_addr == hot_flat[i*ADDR_W +: ADDR_W]);
    assign hit_slot[i] = valid_vec[i] &&
                         (in_addr == slot_addr(slot_flat[i*IDX_W +: IDX_W]));
  end
endmodule

// File: rtl/remap_select.sv
module remap_select
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAIRS  = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]       in_addr,
  input  logic [PAIRS*ADDR_W-1:0] hot_flat,
  input  logic [PAIRS*IDX_W-1:0]  slot_flat,
  input  logic [PAIRS-1:0]        hit_hot,
  input  logic [PAIRS-1:0]        hit_slot,
  output logic [ADDR_W-1:0]       out_addr,
  output logic [PAIRS-1:0]        win_vec,
  output side_e                   win_side
);
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] s);
    return {{(ADDR_W-IDX_W){1'b0}}, s};
  endfunction

  // Priority chain: the lowest index with any match takes the output.
  always_comb begin
    logic taken;
    taken    = 1'b0;
    win_vec  = '0;
    win_side = SIDE_SLOT;
    out_addr = in_addr;
    for (int i = 0; i < PAIRS; i++) begin
      if (!taken && (hit_hot[i] || hit_slot[i])) begin
        taken      = 1'b1;
        win_vec[i] = 1'b1;
        if (hit_hot[i]) begin
          win_side = SIDE_HOT;
          out_addr = slot_addr(slot_flat[i*IDX_W +: IDX_W]);
        end else begin
          win_side = SIDE_SLOT;
          out_addr = hot_flat[i*ADDR_W +: ADDR_W];
        end
      end
    end
  end
endmodule

// File: rtl/addr_swap_remap.sv
module addr_swap_remap
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned PAIRS  = DEF_PAIRS,
  localparam int unsigned IDX_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_hot,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic              cfg_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic [ADDR_W-1:0] out_addr
);
  logic [PAIRS*ADDR_W-1:0] hot_flat;
  logic [PAIRS*IDX_W-1:0]  slot_flat;
  logic [PAIRS-1:0]        valid_vec;
  logic [PAIRS-1:0]        hit_hot;
  logic [PAIRS-1:0]        hit_slot;
  logic [PAIRS-1:0]        hit_vec;
  logic [PAIRS-1:0]        win_vec;
  side_e                   win_side;
  logic                    win_hot;

  assign hit_vec = hit_hot | hit_slot;
  assign win_hot = (win_side == SIDE_HOT);

  remap_table #(.ADDR_W(ADDR_W), .PAIRS(PAIRS), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .hot(cfg_hot),
    .slot(cfg_slot), .valid(cfg_valid), .hot_flat(hot_flat),
    .slot_flat(slot_flat), .valid_vec(valid_vec)
  );

  remap_match #(.ADDR_W(ADDR_W), .PAIRS(PAIRS), .IDX_W(IDX_W)) u_match (
    .in_addr(in_addr), .hot_flat(hot_flat), .slot_flat(slot_flat),
    .valid_vec(valid_vec), .hit_hot(hit_hot), .hit_slot(hit_slot)
  );

  remap_select #(.ADDR_W(ADDR_W), .PAIRS(PAIRS), .IDX_W(IDX_W)) u_select (
    .in_addr(in_addr), .hot_flat(hot_flat), .slot_flat(slot_flat),
    .hit_hot(hit_hot), .hit_slot(hit_slot), .out_addr(out_addr),
    .win_vec(win_vec), .win_side(win_side)
  );
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PAIRS  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] in_addr,
  input logic [ADDR_W-1:0] out_addr,
  input logic [PAIRS-1:0]  valid_vec,
  input logic [PAIRS-1:0]  hit_vec,
  input logic [PAIRS-1:0]  win_vec,
  input logic              win_hot
);
  localparam logic [ADDR_W-1:0] LOW_LIMIT = ADDR_W'(PAIRS);

  p_miss_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec == '0) |-> (out_addr == in_addr));

  p_hot_lands_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_vec != '0) && win_hot) |-> (out_addr < LOW_LIMIT));

  p_slot_from_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_vec != '0) && !win_hot) |-> (in_addr < LOW_LIMIT));

  p_table_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(valid_vec));

  p_invalid_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit_vec & ~valid_vec) == '0));

  p_single_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec) && ((win_vec == '0) == (hit_vec == '0)));

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec != '0) |-> (((win_vec & hit_vec) == win_vec) &&
                         (((win_vec - 1'b1) & hit_vec) == '0)));
endmodule

bind addr_swap_remap remap_chk #(.ADDR_W(ADDR_W), .PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .in_addr(in_addr),
  .out_addr(out_addr), .valid_vec(valid_vec), .hit_vec(hit_vec),
  .win_vec(win_vec), .win_hot(win_hot)
);

// File: tb/sim_addr_swap_remap.sv
`timescale 1ns/1ps
module sim_addr_swap_remap;
  localparam int NP = 8;
  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_hot = '0;
  logic [IW-1:0] cfg_slot = '0;
  logic          cfg_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [AW-1:0] out_addr;

  always #2.5 clk = ~clk;

  addr_swap_remap #(.ADDR_W(AW), .PAIRS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_hot(cfg_hot), .cfg_slot(cfg_slot), .cfg_valid(cfg_valid),
    .in_addr(in_addr), .out_addr(out_addr)
  );

  // Bench's own view of the table.
  logic [AW-1:0] m_hot [NP];
  logic [IW-1:0] m_slot[NP];
  logic          m_val [NP];

  int total = 0;
  int fails = 0;

  typedef struct {
    logic [AW-1:0] a;
    logic [AW-1:0] e;
    string         t;
  } item_t;
  item_t sb[$];

  function automatic logic [AW-1:0] expect_of(input logic [AW-1:0] x);
    for (int i = 0; i < NP; i++) begin
      if (m_val[i]) begin
        if (x == m_hot[i]) return AW'(m_slot[i]);
        if (x == AW'(m_slot[i])) return m_hot[i];
      end
    end
    return x;
  endfunction

  task automatic note(input string t, input logic [AW-1:0] a,
                      input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s in=%h got=%h exp=%h", t, a, got, exp);
    end
  endtask

  // Monitor: pops one expectation per cycle, between clock edges.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      note(it.t, it.a, out_addr, it.e);
    end
  end

  task automatic look(input logic [AW-1:0] x, input string t);
    @(posedge clk); #1;
    in_addr = x;
    sb.push_back('{x, expect_of(x), t});
  endtask

  task automatic wr(input int i, input logic [AW-1:0] h,
                    input logic [IW-1:0] s, input logic v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = IW'(i); cfg_hot = h; cfg_slot = s; cfg_valid = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_hot[i] = h; m_slot[i] = s; m_val[i] = v;
  endtask

  task automatic round_trip(input logic [AW-1:0] x);
    logic [AW-1:0] y;
    @(posedge clk); #1;
    in_addr = x;
    sb.push_back('{x, expect_of(x), "R4"});
    #2;
    y = out_addr;
    @(posedge clk); #1;
    in_addr = y;
    sb.push_back('{y, x, "R4"});
  endtask

  // R9: change the input between edges and look 1 ns later.
  task automatic comb_look(input logic [AW-1:0] x);
    @(negedge clk); #1;
    in_addr = x;
    #1;
    note("R9", x, out_addr, expect_of(x));
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0;
    for (int i = 0; i < NP; i++) m_val[i] = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) begin
      m_hot[i] = '0; m_slot[i] = '0; m_val[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7: empty table after reset, so slot addresses and others pass through.
    for (int i = 0; i < 4; i++) look(AW'(i), "R7");
    look(32'h4000_0000, "R7");

    // Load a unique configuration: slot 7-i paired with a high hot address.
    for (int i = 0; i < NP; i++) wr(i, 32'h4000_0000 + 32'(i) * 32'h104, IW'(NP-1-i), 1'b1);

    for (int i = 0; i < NP; i++) look(32'h4000_0000 + 32'(i) * 32'h104, "R2");
    for (int i = 0; i < NP; i++) look(AW'(i), "R3");
    look(32'h0000_0008, "R1");
    look(32'h4000_0001, "R1");
    look(32'hFFFF_FFFF, "R1");
    look(32'h8000_0007, "R1");

    // R4: round trip on a mix of hot, slot and random addresses.
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] x;
      case (k % 3)
        0: x = 32'h4000_0000 + 32'((k/3) % NP) * 32'h104;
        1: x = AW'(k % NP);
        default: x = $urandom();
      endcase
      round_trip(x);
    end

    // R9: output settles between edges without a clock.
    comb_look(32'h4000_0104);
    comb_look(32'h0000_0002);
    comb_look(32'h1234_5678);
    drain();

    // R5: overwrite entry 3; entry 4 must stay, old hot of 3 now passes.
    wr(3, 32'h5555_0000, 3'd0, 1'b1);
    look(32'h5555_0000, "R5");
    look(32'h4000_030C, "R5");
    look(32'h4000_0410, "R5");
    look(32'h0000_0000, "R5");
    look(32'h0000_0004, "R5");

    // R6: invalid entry carrying a hot address must not match.
    wr(6, 32'hDEAD_BEEF, 3'd1, 1'b0);
    look(32'hDEAD_BEEF, "R6");
    look(32'h0000_0001, "R6");

    // R8: entries 1 and 5 both claim the same hot address; entry 1 wins.
    wr(1, 32'h4000_0514, 3'd6, 1'b1);
    look(32'h4000_0514, "R8");
    wr(0, 32'h4000_0514, 3'd5, 1'b1);
    look(32'h4000_0514, "R8");

    // R7: reset mid-run erases the loaded table.
    drain();
    do_reset();
    look(32'h4000_0514, "R7");
    look(32'h5555_0000, "R7");
    look(32'h0000_0005, "R7");
    drain();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog R1..all: got=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule